// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps time in a low-power domain. A single binary count is split into a whole-seconds word and a sub-second fraction that advances by one on each pulse of a 32 kHz tick. When the count overflows its fraction, the seconds word increments. Software seeds the seconds and fraction words through load strobes that share one data bus. It also holds a level enable for counting. No tick moves the count until the seconds word has been loaded once. Loading the value zero is enough.

A second register pair holds an alarm time in the same split format. The alarm flag is set when a tick moves the count onto the alarm value. The flag stays set until a clear pulse removes it. An interrupt follows the flag whenever the alarm interrupt enable is high; there is no other interrupt source. After reset, a not-valid indication holds the count still until a restore pulse clears it. The surrounding bus logic and any clock-domain crossing sit outside this block.

Top module: `sac_seconds_alarm`

## Requirements
- R1: After reset, `cnt_sec` and `cnt_frac` read 0, `alarm_flag` and `alarm_irq` are 0, and `not_valid` is 1.
- R2: Until `ld_sec` has been pulsed once since reset, ticks leave the count unchanged, even with `run_en` high and the block valid. A load of the value 0 arms the counter.
- R3: While `run_en` is low, ticks leave the count unchanged.
- R4: While `not_valid` is 1, ticks leave the count unchanged. A `restore_valid` pulse clears `not_valid` at the next edge.
- R5: Each accepted tick adds one to the fraction. A fraction of all ones (32767 for the 15-bit default) wraps to 0 and increments the seconds. Seconds 0xFFFFFFFF with fraction 32767 wraps to all zeros.
- R6: `ld_sec` replaces only the seconds word, and `ld_frac` replaces only the fraction, taken from `ld_data[14:0]`. A load takes precedence over a tick in the same cycle, so that tick is dropped and the sub-second phase restarts from the loaded value.
- R7: The alarm words reset to all ones. `alarm_flag` rises at the same edge where a tick moves the count onto the alarm value. A load that makes the count equal to the alarm does not set it.
- R8: `alarm_flag` is sticky and is cleared by an `alarm_clr` pulse. If an alarm match and a clear fall in the same cycle, the flag stays set.
- R9: `alarm_irq` equals `alarm_flag` AND `alarm_ie` in the same cycle. Lowering `alarm_ie` masks the interrupt without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 32 kHz count pulse |
| run_en | input | 1 | Counting enable level |
| ld_data | input | 32 | Shared load data for all four words |
| ld_sec | input | 1 | Load seconds word of the count |
| ld_frac | input | 1 | Load fraction of the count |
| ld_alm_sec | input | 1 | Load seconds word of the alarm |
| ld_alm_frac | input | 1 | Load fraction of the alarm |
| alarm_ie | input | 1 | Alarm interrupt enable level |
| alarm_clr | input | 1 | Write-one-to-clear pulse for the alarm flag |
| restore_valid | input | 1 | Pulse that clears the not-valid indication |
| cnt_sec | output | 32 | Current seconds |
| cnt_frac | output | 15 | Current sub-second fraction |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |
| not_valid | output | 1 | Block not yet validated since reset |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an alarm match and an alarm clear. The bench places the count one tick below the alarm and drives `tick` and `alarm_clr` in the same cycle. It expects the flag to read 1 afterwards, and a later lone clear must return it to 0.

The second pair is a fraction load and a tick. The bench drives both in the same cycle. It expects the fraction to equal the loaded value with no extra increment.

// File: rtl/sac_pkg.sv
package sac_pkg;

   // Write strobes for one split-word register (seconds and fraction)
   typedef struct packed {
      logic sec_w;
      logic frac_w;
   } sac_wr_t;

   localparam int unsigned SAC_SEC_W_DEF  = 32;
   localparam int unsigned SAC_FRAC_W_DEF = 15;

endpackage

// File: rtl/sac_count.sv
module sac_count
   import sac_pkg::*;
#(
   parameter int unsigned SEC_W  = SAC_SEC_W_DEF,
   parameter int unsigned FRAC_W = SAC_FRAC_W_DEF,
   localparam int unsigned CNT_W = SEC_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic             valid,
   input  sac_wr_t          wr,
   input  logic [SEC_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_inc,
   output logic             adv
);

   logic armed_q;
   logic any_wr;

   always_comb begin
      any_wr  = wr.sec_w | wr.frac_w;
      cnt_inc = cnt_q + CNT_W'(1);
      adv     = tick & run_en & valid & armed_q & ~any_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (any_wr) begin
         if (wr.sec_w) begin
            cnt_q[CNT_W-1:FRAC_W] <= wr_data;
            armed_q               <= 1'b1;
         end
         if (wr.frac_w) begin
            cnt_q[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
         end
      end else if (adv) begin
         cnt_q <= cnt_inc;
      end
   end

   assert_frozen_unarmed_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !any_wr) |=> $stable(cnt_q));

   assert_hold_stopped_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !any_wr) |=> $stable(cnt_q));

   assert_hold_invalid_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !any_wr) |=> $stable(cnt_q));

   assert_single_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run_en && valid && armed_q && !any_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   assert_load_wins_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      wr.frac_w |=> (cnt_q[FRAC_W-1:0] == $past(wr_data[FRAC_W-1:0])));

endmodule

// File: rtl/sac_alarm.sv
module sac_alarm
   import sac_pkg::*;
#(
   parameter int unsigned SEC_W  = SAC_SEC_W_DEF,
   parameter int unsigned FRAC_W = SAC_FRAC_W_DEF,
   localparam int unsigned CNT_W = SEC_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sac_wr_t          wr,
   input  logic [SEC_W-1:0] wr_data,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic             adv,
   input  logic             clr,
   output logic             flag_q
);

   logic [CNT_W-1:0] alm_q;
   logic             hit;

   always_comb begin
      hit = adv & (cnt_inc == alm_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_q <= '1;
      end else begin
         if (wr.sec_w) begin
            alm_q[CNT_W-1:FRAC_W] <= wr_data;
         end
         if (wr.frac_w) begin
            alm_q[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
         end
      end
   end

   // a fresh match outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
      end
   end

   assert_match_sets_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (cnt_inc == alm_q)) |=> flag_q);

   assert_no_rise_without_tick_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> !$rose(flag_q));

   assert_flag_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   assert_flag_clears_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !adv) |=> !flag_q);

endmodule

// File: rtl/sac_seconds_alarm.sv
module sac_seconds_alarm
   import sac_pkg::*;
#(
   parameter int unsigned SEC_W   = SAC_SEC_W_DEF,
   parameter int unsigned FRAC_W  = SAC_FRAC_W_DEF,
   parameter bit          IRQ_REG = 1'b0,
   localparam int unsigned CNT_W  = SEC_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run_en,
   input  logic [SEC_W-1:0]  ld_data,
   input  logic              ld_sec,
   input  logic              ld_frac,
   input  logic              ld_alm_sec,
   input  logic              ld_alm_frac,
   input  logic              alarm_ie,
   input  logic              alarm_clr,
   input  logic              restore_valid,
   output logic [SEC_W-1:0]  cnt_sec,
   output logic [FRAC_W-1:0] cnt_frac,
   output logic              alarm_flag,
   output logic              alarm_irq,
   output logic              not_valid
);

   generate
      if (SEC_W < 2 || SEC_W > 32) begin : g_bad_sec_w
         $error("sac_seconds_alarm: SEC_W must lie in 2..32");
      end
      if (FRAC_W < 1 || FRAC_W > SEC_W) begin : g_bad_frac_w
         $error("sac_seconds_alarm: FRAC_W must lie in 1..SEC_W");
      end
   endgenerate

   sac_wr_t          cnt_wr;
   sac_wr_t          alm_wr;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             adv;
   logic             flag_q;
   logic             nv_q;

   always_comb begin
      cnt_wr.sec_w  = ld_sec;
      cnt_wr.frac_w = ld_frac;
      alm_wr.sec_w  = ld_alm_sec;
      alm_wr.frac_w = ld_alm_frac;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q <= 1'b1;
      end else if (restore_valid) begin
         nv_q <= 1'b0;
      end
   end

   sac_count #(
      .SEC_W  (SEC_W),
      .FRAC_W (FRAC_W)
   ) i_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run_en  (run_en),
      .valid   (~nv_q),
      .wr      (cnt_wr),
      .wr_data (ld_data),
      .cnt_q   (cnt_q),
      .cnt_inc (cnt_inc),
      .adv     (adv)
   );

   sac_alarm #(
      .SEC_W  (SEC_W),
      .FRAC_W (FRAC_W)
   ) i_alarm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (alm_wr),
      .wr_data (ld_data),
      .cnt_inc (cnt_inc),
      .adv     (adv),
      .clr     (alarm_clr),
      .flag_q  (flag_q)
   );

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= flag_q & alarm_ie;
            end
         end
         assign alarm_irq = irq_q;
      end else begin : g_irq_comb
         assign alarm_irq = flag_q & alarm_ie;

         assert_irq_masked_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            !alarm_ie |-> !alarm_irq);

         assert_irq_follows_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            (alarm_ie && flag_q) |-> alarm_irq);
      end
   endgenerate

   assign cnt_sec    = cnt_q[CNT_W-1:FRAC_W];
   assign cnt_frac   = cnt_q[FRAC_W-1:0];
   assign alarm_flag = flag_q;
   assign not_valid  = nv_q;

   assert_valid_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !nv_q |=> !nv_q);

endmodule

// File: tb/test_sac_seconds_alarm.sv
module test_sac_seconds_alarm;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        run_en = 1'b0;
   logic [31:0] ld_data = '0;
   logic        ld_sec = 1'b0;
   logic        ld_frac = 1'b0;
   logic        ld_alm_sec = 1'b0;
   logic        ld_alm_frac = 1'b0;
   logic        alarm_ie = 1'b0;
   logic        alarm_clr = 1'b0;
   logic        restore_valid = 1'b0;
   logic [31:0] cnt_sec;
   logic [14:0] cnt_frac;
   logic        alarm_flag;
   logic        alarm_irq;
   logic        not_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sac_seconds_alarm i_sac_seconds_alarm (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .run_en        (run_en),
      .ld_data       (ld_data),
      .ld_sec        (ld_sec),
      .ld_frac       (ld_frac),
      .ld_alm_sec    (ld_alm_sec),
      .ld_alm_frac   (ld_alm_frac),
      .alarm_ie      (alarm_ie),
      .alarm_clr     (alarm_clr),
      .restore_valid (restore_valid),
      .cnt_sec       (cnt_sec),
      .cnt_frac      (cnt_frac),
      .alarm_flag    (alarm_flag),
      .alarm_irq     (alarm_irq),
      .not_valid     (not_valid)
   );

   typedef struct packed {
      logic [31:0] s0;
      logic [14:0] f0;
      logic [7:0]  n;
      logic [31:0] es;
      logic [14:0] ef;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{32'd5,          15'd0,     8'd1,  32'd5,   15'd1},
      '{32'd5,          15'd32767, 8'd1,  32'd6,   15'd0},
      '{32'hFFFF_FFFF,  15'd32767, 8'd1,  32'd0,   15'd0},
      '{32'd100,        15'd32766, 8'd3,  32'd101, 15'd1},
      '{32'd7,          15'd10,    8'd0,  32'd7,   15'd10},
      '{32'd0,          15'd0,     8'd40, 32'd0,   15'd40}
   };

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
      end
   endtask

   // all drive tasks start and end at a falling edge
   task automatic do_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic load_sec(input logic [31:0] v);
      ld_data = v; ld_sec = 1'b1;
      @(negedge clk);
      ld_sec = 1'b0;
   endtask

   task automatic load_frac(input logic [31:0] v);
      ld_data = v; ld_frac = 1'b1;
      @(negedge clk);
      ld_frac = 1'b0;
   endtask

   task automatic load_alarm(input logic [31:0] s, input logic [31:0] f);
      ld_data = s; ld_alm_sec = 1'b1;
      @(negedge clk);
      ld_alm_sec = 1'b0; ld_data = f; ld_alm_frac = 1'b1;
      @(negedge clk);
      ld_alm_frac = 1'b0;
   endtask

   task automatic clear_alarm();
      alarm_clr = 1'b1;
      @(negedge clk);
      alarm_clr = 1'b0;
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired before the bench finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      apply_reset();

      // R1 reset state
      check("R1 sec", cnt_sec, 0);
      check("R1 frac", cnt_frac, 0);
      check("R1 flag", alarm_flag, 0);
      check("R1 irq", alarm_irq, 0);
      check("R1 not_valid", not_valid, 1);

      // R4 restore clears not-valid; R2 unarmed counter stays still
      run_en = 1'b1;
      restore_valid = 1'b1;
      @(negedge clk);
      restore_valid = 1'b0;
      check("R4 restore", not_valid, 0);
      repeat (3) do_tick();
      check("R2 unarmed frac", cnt_frac, 0);
      check("R2 unarmed sec", cnt_sec, 0);
      load_sec(32'd0);
      do_tick();
      check("R2 armed by zero", cnt_frac, 1);

      // R3 stopped
      run_en = 1'b0;
      repeat (2) do_tick();
      check("R3 stopped", cnt_frac, 1);
      run_en = 1'b1;

      // R5 vector walk
      for (int i = 0; i < NVEC; i++) begin
         load_sec(VEC[i].s0);
         load_frac({17'd0, VEC[i].f0});
         for (int k = 0; k < int'(VEC[i].n); k++) do_tick();
         check($sformatf("R5 vec%0d sec", i), cnt_sec, VEC[i].es);
         check($sformatf("R5 vec%0d frac", i), cnt_frac, VEC[i].ef);
      end

      // R6 partial loads and load over tick
      load_frac(32'd5);
      load_sec(32'd9);
      check("R6 sec load", cnt_sec, 9);
      check("R6 frac kept", cnt_frac, 5);
      ld_data = 32'd100; ld_frac = 1'b1; tick = 1'b1;
      @(negedge clk);
      ld_frac = 1'b0; tick = 1'b0;
      check("R6 load beats tick", cnt_frac, 100);
      check("R6 sec kept", cnt_sec, 9);

      // R7 reset alarm is all ones; load does not match
      load_sec(32'hFFFF_FFFF);
      load_frac(32'h7FFF);
      check("R7 load no match", alarm_flag, 0);
      load_frac(32'h7FFE);
      do_tick();
      check("R7 tick onto reset alarm", alarm_flag, 1);
      clear_alarm();
      check("R8 clear", alarm_flag, 0);

      // R7/R9 programmed alarm
      load_alarm(32'd20, 32'd0);
      load_sec(32'd19);
      load_frac(32'h7FFE);
      do_tick();
      check("R7 one before", alarm_flag, 0);
      alarm_ie = 1'b1;
      #1;
      check("R9 no irq without flag", alarm_irq, 0);
      @(negedge clk);
      do_tick();
      check("R7 sec at match", cnt_sec, 20);
      check("R7 flag at match", alarm_flag, 1);
      check("R9 irq", alarm_irq, 1);
      alarm_ie = 1'b0;
      #1;
      check("R9 masked irq", alarm_irq, 0);
      check("R9 flag kept", alarm_flag, 1);
      @(negedge clk);
      repeat (2) do_tick();
      check("R8 sticky", alarm_flag, 1);
      alarm_ie = 1'b1;

      // R8 match and clear in the same cycle
      clear_alarm();
      check("R8 cleared", alarm_flag, 0);
      load_sec(32'd19);
      load_frac(32'h7FFF);
      tick = 1'b1; alarm_clr = 1'b1;
      @(negedge clk);
      tick = 1'b0; alarm_clr = 1'b0;
      check("R8 set beats clear", alarm_flag, 1);
      clear_alarm();
      check("R8 lone clear", alarm_flag, 0);

      // R4 invalid blocks counting after a fresh reset
      apply_reset();
      check("R1 not_valid again", not_valid, 1);
      check("R1 sec again", cnt_sec, 0);
      load_sec(32'd3);
      do_tick();
      check("R4 invalid frozen", cnt_frac, 0);
      restore_valid = 1'b1;
      @(negedge clk);
      restore_valid = 1'b0;
      do_tick();
      check("R4 counts when valid", cnt_frac, 1);
      check("R4 sec", cnt_sec, 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule